// File: doc/BRIEF.md
# BCD Real-Time Calendar with Dual Alarms

This block keeps wall-clock time and calendar date from a slow reference clock (nominally 32.768 kHz). A two-stage down-counting prescaler divides the reference into a one-second tick. On each tick the seconds advance, and the carry ripples through minutes, hours, weekday, day of month, month and a two-digit year. Every field is held and counted directly in packed BCD. The day of month rolls over correctly for months of 28, 29, 30 and 31 days, and February gets its leap day.

Hours run in 24-hour form or in 12-hour form with an afternoon flag, chosen by a mode input. Software sets the time through a parallel load strobe. The strobe also restarts the prescaler, so the loaded value lasts one full second. Two independent alarm comparators watch the time after each tick. Each one can leave any field out of the comparison, and each raises a sticky flag. A square wave taken from the first prescaler stage is available for measuring the reference frequency.

Top module: `rtc_calendar`

## Requirements
- R1: The tick fires once every (PA_INIT+1)*(PS_INIT+1) clock cycles (32768 with defaults). The time fields change only on the edge where the tick is high.
- R2: Seconds and minutes count 00..59 in BCD. The step after 59 gives 00 and carries into the next field. A BCD digit 9 steps to 0 and increments the tens digit.
- R3: With fmt12_i=0, hours count 00..23 (pm_o stays 0). A carry out of 23 gives 00 and advances the day.
- R4: With fmt12_i=1, hours run 12,01..11 with pm_o (1=afternoon). 11 becomes 12 and toggles pm_o. 12 becomes 01 and keeps pm_o. The day advances when 11 PM becomes 12 AM.
- R5: On a day advance, the last date of the month gives 01 and steps the month. April, June, September and November have 30 days. February has 28 days, or 29 when the year value is divisible by 4 (including 00). All other months have 31 days. Month 12 steps to 01 and increments the year, and year 99 steps to 00.
- R6: The weekday counts 1..7 and steps from 7 to 1 on each day advance.
- R7: When load_i is high at an edge, every time field takes its ld_* value and both prescaler stages reload. The next tick then comes a full period (R1) after that edge.
- R8: cal_o is bit CAL_BIT of the first prescaler stage, which counts down from PA_INIT. With defaults this gives a 512 Hz square wave at 50% duty.
- R9: The cycle after a tick, alarm k sets alm_flag_o[k] if every unmasked field equals its alarm value. The mask bits are 1=ignore, with bit0 seconds, bit1 minutes, bit2 hour together with the pm flag, bit3 date and bit4 weekday.
- R10: An alarm flag stays set until alm_clr_i[k] is high at an edge. If a set and a clear fall on the same edge, the set wins.
- R11: After reset the time reads 00:00:00 with pm_o=0, weekday 1, date 01, month 01, year 00, and both flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt12_i | input | 1 | 1 selects 12-hour mode |
| load_i | input | 1 | Time load strobe |
| ld_sec_i | input | 8 | Seconds to load (BCD) |
| ld_min_i | input | 8 | Minutes to load (BCD) |
| ld_hour_i | input | 8 | Hours to load (BCD) |
| ld_pm_i | input | 1 | Afternoon flag to load |
| ld_wday_i | input | 3 | Weekday to load, 1..7 |
| ld_date_i | input | 8 | Date to load (BCD) |
| ld_month_i | input | 8 | Month to load (BCD) |
| ld_year_i | input | 8 | Year to load (BCD) |
| alm_sec_i | input | NUM_ALM*8 | Alarm seconds per alarm |
| alm_min_i | input | NUM_ALM*8 | Alarm minutes per alarm |
| alm_hour_i | input | NUM_ALM*8 | Alarm hours per alarm |
| alm_pm_i | input | NUM_ALM | Alarm afternoon flag per alarm |
| alm_wday_i | input | NUM_ALM*3 | Alarm weekday per alarm |
| alm_date_i | input | NUM_ALM*8 | Alarm date per alarm |
| alm_mask_i | input | NUM_ALM*5 | Field ignore mask per alarm |
| alm_clr_i | input | NUM_ALM | Flag clear pulse per alarm |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours |
| pm_o | output | 1 | Afternoon flag |
| wday_o | output | 3 | Weekday |
| date_o | output | 8 | Date |
| month_o | output | 8 | Month |
| year_o | output | 8 | Year |
| alm_flag_o | output | NUM_ALM | Sticky alarm flags |
| tick_o | output | 1 | One-second tick |
| cal_o | output | 1 | Calibration square wave |

## Verification
A table of times is loaded one at a time, and each is followed by exactly one tick. Some entries stop short of a carry, and others sit on the seconds, minutes, hour or BCD-digit boundaries. The remaining entries sit on the last day of 30-day, 31-day and February months, both in leap years (including 00) and in common years, and at the year wrap. Together these separate a plain binary increment, a wrong month-length table and a misplaced leap rule. The same hour edges are repeated in 12-hour mode at 11 AM, 11 PM and 12 PM and AM, which exposes a wrong afternoon toggle or a day carry at noon. Directed cases cover tick spacing, reload on load, the calibration waveform, single-field and full-field alarm matches and mismatches, flag stickiness, and set-over-clear priority.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned FLD_SEC  = 0;
  localparam int unsigned FLD_MIN  = 1;
  localparam int unsigned FLD_HOUR = 2;
  localparam int unsigned FLD_DATE = 3;
  localparam int unsigned FLD_WDAY = 4;
  localparam int unsigned NUM_FLD  = 5;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic leap_yr(input logic [7:0] y);
    logic [7:0] bin;
    bin = ({4'd0, y[7:4]} * 8'd10) + {4'd0, y[3:0]};
    return bin[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] month_end(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return leap_yr(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned PA_W    = 7,
  parameter int unsigned PS_W    = 13,
  parameter int unsigned PA_INIT = 127,
  parameter int unsigned PS_INIT = 255,
  parameter int unsigned CAL_BIT = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  output logic tick_o,
  output logic cal_o
);
  localparam logic [PA_W-1:0] A_RLD = PA_W'(PA_INIT);
  localparam logic [PS_W-1:0] S_RLD = PS_W'(PS_INIT);

  logic [PA_W-1:0] a_q;
  logic [PS_W-1:0] s_q;
  logic a_wrap;

  assign a_wrap = (a_q == '0);
  assign tick_o = a_wrap && (s_q == '0) && !hold_i;
  assign cal_o  = a_q[CAL_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= A_RLD;
      s_q <= S_RLD;
    end else if (hold_i) begin
      a_q <= A_RLD;
      s_q <= S_RLD;
    end else begin
      a_q <= a_wrap ? A_RLD : a_q - 1'b1;
      if (a_wrap) s_q <= (s_q == '0) ? S_RLD : s_q - 1'b1;
    end
  end
endmodule

// File: rtl/rtc_bcd_cal.sv
module rtc_bcd_cal
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       load_i,
  input  logic       fmt12_i,
  input  logic [7:0] ld_sec_i,
  input  logic [7:0] ld_min_i,
  input  logic [7:0] ld_hour_i,
  input  logic       ld_pm_i,
  input  logic [2:0] ld_wday_i,
  input  logic [7:0] ld_date_i,
  input  logic [7:0] ld_month_i,
  input  logic [7:0] ld_year_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic       pm_o,
  output logic [2:0] wday_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o
);
  logic [7:0] sec_n, min_n, hour_n, date_n, month_n, year_n;
  logic [2:0] wday_n;
  logic       pm_n, c_min, c_hr, c_day;

  always_comb begin
    min_n   = min_o;
    hour_n  = hour_o;
    pm_n    = pm_o;
    wday_n  = wday_o;
    date_n  = date_o;
    month_n = month_o;
    year_n  = year_o;
    c_day   = 1'b0;
    c_min   = (sec_o == 8'h59);
    c_hr    = c_min && (min_o == 8'h59);
    sec_n   = c_min ? 8'h00 : bcd_inc(sec_o);
    if (c_min) min_n = (min_o == 8'h59) ? 8'h00 : bcd_inc(min_o);
    if (c_hr) begin
      if (fmt12_i) begin
        if (hour_o == 8'h11) begin
          hour_n = 8'h12;
          pm_n   = ~pm_o;
          c_day  = pm_o;
        end else if (hour_o == 8'h12) begin
          hour_n = 8'h01;
        end else begin
          hour_n = bcd_inc(hour_o);
        end
      end else if (hour_o == 8'h23) begin
        hour_n = 8'h00;
        c_day  = 1'b1;
      end else begin
        hour_n = bcd_inc(hour_o);
      end
    end
    if (c_day) begin
      wday_n = (wday_o == 3'd7) ? 3'd1 : wday_o + 3'd1;
      if (date_o == month_end(month_o, year_o)) begin
        date_n = 8'h01;
        if (month_o == 8'h12) begin
          month_n = 8'h01;
          year_n  = (year_o == 8'h99) ? 8'h00 : bcd_inc(year_o);
        end else begin
          month_n = bcd_inc(month_o);
        end
      end else begin
        date_n = bcd_inc(date_o);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_o   <= 8'h00;
      min_o   <= 8'h00;
      hour_o  <= 8'h00;
      pm_o    <= 1'b0;
      wday_o  <= 3'd1;
      date_o  <= 8'h01;
      month_o <= 8'h01;
      year_o  <= 8'h00;
    end else if (load_i) begin
      sec_o   <= ld_sec_i;
      min_o   <= ld_min_i;
      hour_o  <= ld_hour_i;
      pm_o    <= ld_pm_i;
      wday_o  <= ld_wday_i;
      date_o  <= ld_date_i;
      month_o <= ld_month_i;
      year_o  <= ld_year_i;
    end else if (tick_i) begin
      sec_o   <= sec_n;
      min_o   <= min_n;
      hour_o  <= hour_n;
      pm_o    <= pm_n;
      wday_o  <= wday_n;
      date_o  <= date_n;
      month_o <= month_n;
      year_o  <= year_n;
    end
  end
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               clr_i,
  input  logic [NUM_FLD-1:0] mask_i,
  input  logic [7:0]         a_sec_i,
  input  logic [7:0]         a_min_i,
  input  logic [7:0]         a_hour_i,
  input  logic               a_pm_i,
  input  logic [2:0]         a_wday_i,
  input  logic [7:0]         a_date_i,
  input  logic [7:0]         sec_i,
  input  logic [7:0]         min_i,
  input  logic [7:0]         hour_i,
  input  logic               pm_i,
  input  logic [2:0]         wday_i,
  input  logic [7:0]         date_i,
  output logic               flag_o
);
  logic [NUM_FLD-1:0] hit;
  logic tick_d;

  // compare the value the tick just produced
  assign hit[FLD_SEC]  = mask_i[FLD_SEC]  || (sec_i == a_sec_i);
  assign hit[FLD_MIN]  = mask_i[FLD_MIN]  || (min_i == a_min_i);
  assign hit[FLD_HOUR] = mask_i[FLD_HOUR] || ({pm_i, hour_i} == {a_pm_i, a_hour_i});
  assign hit[FLD_DATE] = mask_i[FLD_DATE] || (date_i == a_date_i);
  assign hit[FLD_WDAY] = mask_i[FLD_WDAY] || (wday_i == a_wday_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_d <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      tick_d <= tick_i;
      if (tick_d && (&hit)) flag_o <= 1'b1;
      else if (clr_i)       flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int unsigned NUM_ALM = 2,
  parameter int unsigned PA_W    = 7,
  parameter int unsigned PS_W    = 13,
  parameter int unsigned PA_INIT = 127,
  parameter int unsigned PS_INIT = 255,
  parameter int unsigned CAL_BIT = 5
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             fmt12_i,
  input  logic                             load_i,
  input  logic [7:0]                       ld_sec_i,
  input  logic [7:0]                       ld_min_i,
  input  logic [7:0]                       ld_hour_i,
  input  logic                             ld_pm_i,
  input  logic [2:0]                       ld_wday_i,
  input  logic [7:0]                       ld_date_i,
  input  logic [7:0]                       ld_month_i,
  input  logic [7:0]                       ld_year_i,
  input  logic [NUM_ALM-1:0][7:0]          alm_sec_i,
  input  logic [NUM_ALM-1:0][7:0]          alm_min_i,
  input  logic [NUM_ALM-1:0][7:0]          alm_hour_i,
  input  logic [NUM_ALM-1:0]               alm_pm_i,
  input  logic [NUM_ALM-1:0][2:0]          alm_wday_i,
  input  logic [NUM_ALM-1:0][7:0]          alm_date_i,
  input  logic [NUM_ALM-1:0][NUM_FLD-1:0]  alm_mask_i,
  input  logic [NUM_ALM-1:0]               alm_clr_i,
  output logic [7:0]                       sec_o,
  output logic [7:0]                       min_o,
  output logic [7:0]                       hour_o,
  output logic                             pm_o,
  output logic [2:0]                       wday_o,
  output logic [7:0]                       date_o,
  output logic [7:0]                       month_o,
  output logic [7:0]                       year_o,
  output logic [NUM_ALM-1:0]               alm_flag_o,
  output logic                             tick_o,
  output logic                             cal_o
);
  rtc_prescaler #(
    .PA_W(PA_W), .PS_W(PS_W), .PA_INIT(PA_INIT), .PS_INIT(PS_INIT), .CAL_BIT(CAL_BIT)
  ) u_presc (
    .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(load_i), .tick_o(tick_o), .cal_o(cal_o)
  );

  rtc_bcd_cal u_cal (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_o), .load_i(load_i), .fmt12_i(fmt12_i),
    .ld_sec_i(ld_sec_i), .ld_min_i(ld_min_i), .ld_hour_i(ld_hour_i), .ld_pm_i(ld_pm_i),
    .ld_wday_i(ld_wday_i), .ld_date_i(ld_date_i), .ld_month_i(ld_month_i),
    .ld_year_i(ld_year_i),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .pm_o(pm_o), .wday_o(wday_o),
    .date_o(date_o), .month_o(month_o), .year_o(year_o)
  );

  for (genvar k = 0; k < NUM_ALM; k++) begin : g_alm
    rtc_alarm u_alm (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_o), .clr_i(alm_clr_i[k]),
      .mask_i(alm_mask_i[k]), .a_sec_i(alm_sec_i[k]), .a_min_i(alm_min_i[k]),
      .a_hour_i(alm_hour_i[k]), .a_pm_i(alm_pm_i[k]), .a_wday_i(alm_wday_i[k]),
      .a_date_i(alm_date_i[k]),
      .sec_i(sec_o), .min_i(min_o), .hour_i(hour_o), .pm_i(pm_o), .wday_i(wday_o),
      .date_i(date_o), .flag_o(alm_flag_o[k])
    );
  end
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk #(
  parameter int unsigned NUM_ALM = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               load_i,
  input logic               tick_o,
  input logic [7:0]         ld_sec_i,
  input logic [7:0]         sec_o,
  input logic [7:0]         min_o,
  input logic [7:0]         hour_o,
  input logic [2:0]         wday_o,
  input logic [7:0]         date_o,
  input logic [7:0]         month_o,
  input logic [NUM_ALM-1:0] alm_flag_o,
  input logic [NUM_ALM-1:0] alm_clr_i
);
  a_r1_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_o && !load_i) |=> $stable({sec_o, min_o, hour_o, date_o, month_o}));
  a_r1_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  a_r2_sec_min_bcd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_o[3:0] <= 4'd9) && (sec_o <= 8'h59) && (min_o[3:0] <= 4'd9) && (min_o <= 8'h59));
  a_r3_hour_bcd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hour_o[3:0] <= 4'd9) && (hour_o <= 8'h23));
  a_r5_date_month_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (date_o != 8'h00) && (date_o <= 8'h31) && (month_o != 8'h00) && (month_o <= 8'h12));
  a_r6_wday_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wday_o != 3'd0));
  a_r7_load_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (sec_o == $past(ld_sec_i)));
  a_r9_set_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((alm_flag_o & ~$past(alm_flag_o)) != '0) |-> $past(tick_o, 2));
  a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((alm_flag_o & $past(alm_flag_o & ~alm_clr_i)) == $past(alm_flag_o & ~alm_clr_i)));
endmodule

bind rtc_calendar rtc_calendar_chk #(.NUM_ALM(NUM_ALM)) u_chk (.*);

// File: tb/rtc_calendar_tb.sv
`timescale 1ns/1ps
module rtc_calendar_tb;
  localparam int unsigned NA = 2;
  localparam int unsigned PER = 32; // (7+1)*(3+1)

  typedef struct packed {
    logic       fmt;
    logic [7:0] s, m, h;
    logic       pm;
    logic [2:0] w;
    logic [7:0] d, mo, y;
    logic [7:0] es, em, eh;
    logic       epm;
    logic [2:0] ew;
    logic [7:0] ed, emo, ey;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00,8'h00,8'h00,1'b0,3'd1,8'h01,8'h01,8'h00, 8'h01,8'h00,8'h00,1'b0,3'd1,8'h01,8'h01,8'h00},
    '{1'b0, 8'h59,8'h00,8'h00,1'b0,3'd1,8'h01,8'h01,8'h00, 8'h00,8'h01,8'h00,1'b0,3'd1,8'h01,8'h01,8'h00},
    '{1'b0, 8'h59,8'h59,8'h00,1'b0,3'd2,8'h05,8'h03,8'h10, 8'h00,8'h00,8'h01,1'b0,3'd2,8'h05,8'h03,8'h10},
    '{1'b0, 8'h59,8'h59,8'h23,1'b0,3'd3,8'h15,8'h06,8'h24, 8'h00,8'h00,8'h00,1'b0,3'd4,8'h16,8'h06,8'h24},
    '{1'b0, 8'h59,8'h59,8'h23,1'b0,3'd7,8'h09,8'h08,8'h21, 8'h00,8'h00,8'h00,1'b0,3'd1,8'h10,8'h08,8'h21},
    '{1'b0, 8'h59,8'h59,8'h23,1'b0,3'd2,8'h30,8'h04,8'h19, 8'h00,8'h00,8'h00,1'b0,3'd3,8'h01,8'h05,8'h19},
    '{1'b0, 8'h59,8'h59,8'h23,1'b0,3'd5,8'h31,8'h01,8'h22, 8'h00,8'h00,8'h00,1'b0,3'd6,8'h01,8'h02,8'h22},
    '{1'b0, 8'h59,8'h59,8'h23,1'b0,3'd1,8'h28,8'h02,8'h23, 8'h00,8'h00,8'h00,1'b0,3'd2,8'h01,8'h03,8'h23},
    '{1'b0, 8'h59,8'h59,8'h23,1'b0,3'd1,8'h28,8'h02,8'h24, 8'h00,8'h00,8'h00,1'b0,3'd2,8'h29,8'h02,8'h24},
    '{1'b0, 8'h59,8'h59,8'h23,1'b0,3'd2,8'h29,8'h02,8'h24, 8'h00,8'h00,8'h00,1'b0,3'd3,8'h01,8'h03,8'h24},
    '{1'b0, 8'h59,8'h59,8'h23,1'b0,3'd4,8'h31,8'h12,8'h99, 8'h00,8'h00,8'h00,1'b0,3'd5,8'h01,8'h01,8'h00},
    '{1'b0, 8'h59,8'h59,8'h23,1'b0,3'd6,8'h30,8'h06,8'h15, 8'h00,8'h00,8'h00,1'b0,3'd7,8'h01,8'h07,8'h15},
    '{1'b0, 8'h59,8'h59,8'h23,1'b0,3'd3,8'h28,8'h02,8'h00, 8'h00,8'h00,8'h00,1'b0,3'd4,8'h29,8'h02,8'h00},
    '{1'b0, 8'h59,8'h59,8'h09,1'b0,3'd1,8'h10,8'h10,8'h10, 8'h00,8'h00,8'h10,1'b0,3'd1,8'h10,8'h10,8'h10},
    '{1'b0, 8'h59,8'h59,8'h19,1'b0,3'd1,8'h31,8'h10,8'h10, 8'h00,8'h00,8'h20,1'b0,3'd1,8'h31,8'h10,8'h10},
    '{1'b1, 8'h59,8'h59,8'h11,1'b0,3'd1,8'h10,8'h10,8'h10, 8'h00,8'h00,8'h12,1'b1,3'd1,8'h10,8'h10,8'h10},
    '{1'b1, 8'h59,8'h59,8'h12,1'b1,3'd1,8'h10,8'h10,8'h10, 8'h00,8'h00,8'h01,1'b1,3'd1,8'h10,8'h10,8'h10},
    '{1'b1, 8'h59,8'h59,8'h11,1'b1,3'd1,8'h10,8'h10,8'h10, 8'h00,8'h00,8'h12,1'b0,3'd2,8'h11,8'h10,8'h10},
    '{1'b1, 8'h59,8'h59,8'h12,1'b0,3'd1,8'h10,8'h10,8'h10, 8'h00,8'h00,8'h01,1'b0,3'd1,8'h10,8'h10,8'h10}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic fmt12_i = 1'b0, load_i = 1'b0, ld_pm_i = 1'b0;
  logic [7:0] ld_sec_i = '0, ld_min_i = '0, ld_hour_i = '0, ld_date_i = 8'h01,
              ld_month_i = 8'h01, ld_year_i = '0;
  logic [2:0] ld_wday_i = 3'd1;
  logic [NA-1:0][7:0] alm_sec_i = '0, alm_min_i = '0, alm_hour_i = '0, alm_date_i = '0;
  logic [NA-1:0]      alm_pm_i = '0, alm_clr_i = '0;
  logic [NA-1:0][2:0] alm_wday_i = '0;
  logic [NA-1:0][4:0] alm_mask_i = '0;
  logic [7:0] sec_o, min_o, hour_o, date_o, month_o, year_o;
  logic       pm_o, tick_o, cal_o;
  logic [2:0] wday_o;
  logic [NA-1:0] alm_flag_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  rtc_calendar #(
    .NUM_ALM(NA), .PA_W(3), .PS_W(13), .PA_INIT(7), .PS_INIT(3), .CAL_BIT(1)
  ) u_dut (.clk_i(clk), .*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load(input logic f, input logic [7:0] s, m, h, input logic pm,
                      input logic [2:0] w, input logic [7:0] d, mo, y);
    fmt12_i = f; ld_sec_i = s; ld_min_i = m; ld_hour_i = h; ld_pm_i = pm;
    ld_wday_i = w; ld_date_i = d; ld_month_i = mo; ld_year_i = y;
    load_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    load_i = 1'b0;
  endtask

  initial begin
    alm_date_i = '0; // never matches a valid date
    repeat (3) @(negedge clk);
    chk("R11 flags in reset", 32'(alm_flag_o), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R11 time", {sec_o, min_o, hour_o, 7'd0, pm_o}, 32'h0);
    chk("R11 date", {5'd0, wday_o, date_o, month_o, year_o}, {5'd0, 3'd1, 8'h01, 8'h01, 8'h00});
    chk("R11 flags", 32'(alm_flag_o), 32'h0);

    for (int i = 0; i < NV; i++) begin
      load(VECS[i].fmt, VECS[i].s, VECS[i].m, VECS[i].h, VECS[i].pm, VECS[i].w,
           VECS[i].d, VECS[i].mo, VECS[i].y);
      edges(PER);
      chk("R2 sec/min", {sec_o, min_o}, {VECS[i].es, VECS[i].em});
      if (VECS[i].fmt) chk("R4 hour12", {hour_o, 7'd0, pm_o}, {VECS[i].eh, 7'd0, VECS[i].epm});
      else             chk("R3 hour24", {hour_o, 7'd0, pm_o}, {VECS[i].eh, 7'd0, VECS[i].epm});
      chk("R6 weekday", 32'(wday_o), 32'(VECS[i].ew));
      chk("R5 date", {date_o, month_o, year_o}, {VECS[i].ed, VECS[i].emo, VECS[i].ey});
    end

    // R1 / R7 / R8: period, reload, calibration pattern
    load(1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 3'd1, 8'h01, 8'h01, 8'h00);
    for (int k = 0; k < 8; k++) begin
      chk("R8 cal", 32'(cal_o), 32'(((7 - k) >> 1) & 1));
      @(negedge clk);
    end
    load(1'b0, 8'h30, 8'h00, 8'h00, 1'b0, 3'd1, 8'h01, 8'h01, 8'h00);
    chk("R7 loaded", 32'(sec_o), 32'h30);
    edges(PER - 1);
    chk("R7 full second", 32'(sec_o), 32'h30);
    chk("R1 tick", 32'(tick_o), 32'h1);
    edges(1);
    chk("R1 first step", 32'(sec_o), 32'h31);
    chk("R1 tick low", 32'(tick_o), 32'h0);
    edges(PER - 1);
    chk("R1 before second step", 32'(sec_o), 32'h31);
    edges(1);
    chk("R1 second step", 32'(sec_o), 32'h32);

    // R9: single-field alarm on seconds, full-field alarm mismatching on date
    alm_sec_i[0] = 8'h05; alm_mask_i[0] = 5'b11110;
    alm_sec_i[1] = 8'h05; alm_min_i[1] = 8'h00; alm_hour_i[1] = 8'h00; alm_pm_i[1] = 1'b0;
    alm_wday_i[1] = 3'd1; alm_date_i[1] = 8'h02; alm_mask_i[1] = 5'b00000;
    load(1'b0, 8'h04, 8'h00, 8'h00, 1'b0, 3'd1, 8'h01, 8'h01, 8'h00);
    edges(PER);
    chk("R9 not before compare", 32'(alm_flag_o[0]), 32'h0);
    edges(1);
    chk("R9 sec match", 32'(alm_flag_o[0]), 32'h1);
    chk("R9 date mismatch", 32'(alm_flag_o[1]), 32'h0);
    edges(PER);
    chk("R10 sticky", 32'(alm_flag_o[0]), 32'h1);
    alm_clr_i[0] = 1'b1;
    @(negedge clk);
    alm_clr_i[0] = 1'b0;
    chk("R10 cleared", 32'(alm_flag_o[0]), 32'h0);

    // R9: all fields match on alarm 1
    alm_date_i[1] = 8'h01;
    load(1'b0, 8'h04, 8'h00, 8'h00, 1'b0, 3'd1, 8'h01, 8'h01, 8'h00);
    edges(PER + 1);
    chk("R9 full match", 32'(alm_flag_o[1]), 32'h1);

    // R10: set beats clear on same edge
    alm_mask_i[0] = 5'b11111;
    load(1'b0, 8'h10, 8'h00, 8'h00, 1'b0, 3'd1, 8'h01, 8'h01, 8'h00);
    edges(PER);
    alm_clr_i[0] = 1'b1;
    @(negedge clk);
    alm_clr_i[0] = 1'b0;
    chk("R10 set over clear", 32'(alm_flag_o[0]), 32'h1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule